// File: doc/BRIEF.md
# Calendar Clock Time Transfer Sequencer

This block moves a complete calendar time between the system and an external clock chip that keeps every field as a pair of 4-bit BCD digits in separate registers. It does not drive the serial wires itself. It issues one nibble access at a time to a register master through a request/acknowledge port, and it owns the chip-enable line that frames each session with the chip.

A command is accepted on `start_i`. The `write_i` input selects the direction: 1 sets the time and 0 reads it. Each session begins with a busy handshake. The block writes the supplied control value to the control register, then reads that register back and tests its busy bit. While the chip reports busy, the block releases chip-enable, waits a fixed number of system clocks and tries again. There is a limit on the number of attempts. Once the handshake succeeds, the block walks seconds, minutes, hours, day, month and year, accessing the ones digit before the tens digit of each. The weekday nibble comes last. On a read, each digit pair becomes a binary value. On a write, each binary value becomes BCD, and the year is first wrapped into two digits.

The session ends in one of two ways. A one-cycle done pulse reports success. A one-cycle error pulse reports that every busy check failed, and in that case no calendar register was touched.

Top module: `rtc_time_seq`

## Requirements
- R1: While reset is asserted and after it is released, chip-enable, request, done and error are all low and every time output is zero.
- R2: A command raises chip-enable. It then writes `ctrl_val_i` to address `ADDR_CTRL` (default 15) and reads address `ADDR_CTRL` back. A clear bit `BUSY_BIT` in that read lets the field transfer begin.
- R3: If the busy bit is set, chip-enable goes low for at least `WAIT_CYC` clocks. The control write and read-back are then repeated with chip-enable high. One attempt is one such write and read pair.
- R4: If all `RETRY_MAX` (default 10) attempts read busy, the block pulses `err_o` for one cycle with chip-enable low and makes no calendar register access. With one busy read fewer, the command still succeeds.
- R5: Field accesses follow a fixed order, with the ones digit of each field before its tens digit. The default addresses are: seconds 0/1, minutes 2/3, hours 4/5, day 7/8, month 9/10, year 11/12, and weekday 6 last. That makes 13 accesses in the address order 0,1,2,3,4,5,7,8,9,10,11,12,6.
- R6: On a read, each time output equals tens*10 + ones of its digit pair and the weekday output equals the weekday nibble. All outputs change only in the cycle in which `done_o` is high.
- R7: On a write, each field goes out as BCD, with the low nibble to the ones address and the high nibble to the tens address. The weekday nibble is written unchanged.
- R8: On a write, a year input of 100 or more is reduced modulo 100 before conversion (for example, 123 is written as digits 2 and 3).
- R9: After the weekday access, chip-enable goes low and `done_o` is high for exactly one cycle.
- R10: `done_o` and `err_o` are never high together. A failed command leaves every time output unchanged.
- R11: A request is only raised with chip-enable high. While a request waits for its acknowledge, the address, direction and write data stay stable.
- R12: A `start_i` pulse while a command is in progress is ignored. The running command completes once with its original direction and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a command (accepted when idle) |
| write_i | input | 1 | 1 = set time, 0 = read time |
| ctrl_val_i | input | 4 | Value written to the control register before each busy check |
| sec_i | input | 7 | Seconds to write (binary) |
| min_i | input | 7 | Minutes to write |
| hour_i | input | 7 | Hours to write |
| day_i | input | 7 | Day of month to write |
| mon_i | input | 7 | Month to write |
| year_i | input | 7 | Year to write, wrapped modulo 100 |
| wday_i | input | 4 | Weekday nibble to write |
| sec_o | output | 7 | Seconds read (binary) |
| min_o | output | 7 | Minutes read |
| hour_o | output | 7 | Hours read |
| day_o | output | 7 | Day read |
| mon_o | output | 7 | Month read |
| year_o | output | 7 | Two-digit year read |
| wday_o | output | 4 | Weekday nibble read |
| done_o | output | 1 | One-cycle pulse on success |
| err_o | output | 1 | One-cycle pulse when all busy checks fail |
| ce_o | output | 1 | Chip-enable to the clock chip |
| reg_req_o | output | 1 | Nibble access request to the register master |
| reg_wr_o | output | 1 | Access direction, 1 = write |
| reg_addr_o | output | 4 | Chip register address |
| reg_wdata_o | output | 4 | Write nibble |
| reg_ack_i | input | 1 | One-cycle access completion |
| reg_rdata_i | input | 4 | Read nibble, valid with the acknowledge |

## Verification
The bench builds the block with `WAIT_CYC` = 4, `BUSY_BIT` = 1 and the default `RETRY_MAX` of 10. The short retry gap keeps even the fully exhausted ten-attempt case within a few hundred clocks. Moving the busy flag off its default position shows that the tested bit follows the parameter. With the retry limit at its default, the bench can compare nine busy reads (success on the last attempt) against ten busy reads (error) directly.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

    localparam int NFIELD = 6;              // sec, min, hour, day, month, year
    localparam int NITEM  = 2 * NFIELD + 1; // digit pairs plus weekday
    localparam int BINW   = 7;              // binary field width
    localparam int NIBW   = 4;              // register nibble width

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTL_WR,
        S_CTL_RD,
        S_WAIT,
        S_XFER,
        S_FIN
    } seq_state_e;

endpackage

// File: rtl/rtc_bin2bcd.sv
module rtc_bin2bcd #(
    parameter bit WRAP = 1'b0
) (
    input  logic [6:0] bin_i,
    output logic [7:0] bcd_o
);
    logic [6:0] val;

    generate
        if (WRAP) begin : g_wrap
            assign val = (bin_i >= 7'd100) ? (bin_i - 7'd100) : bin_i;
        end else begin : g_plain
            assign val = bin_i;
        end
    endgenerate

    assign bcd_o = {4'(val / 7'd10), 4'(val % 7'd10)};
endmodule

// File: rtl/rtc_bcd2bin.sv
module rtc_bcd2bin (
    input  logic [3:0] ones_i,
    input  logic [3:0] tens_i,
    output logic [6:0] bin_o
);
    assign bin_o = 7'({3'b000, tens_i} * 7'd10 + {3'b000, ones_i});
endmodule

// File: rtl/rtc_wait_timer.sv
module rtc_wait_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic expired_o
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CW'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/rtc_time_seq.sv
module rtc_time_seq
    import rtc_seq_pkg::*;
#(
    parameter int         RETRY_MAX   = 10,
    parameter int         WAIT_CYC    = 8,
    parameter int         BUSY_BIT    = 3,
    parameter logic [3:0] ADDR_CTRL   = 4'd15,
    parameter logic [3:0] ADDR_SEC1   = 4'd0,
    parameter logic [3:0] ADDR_SEC10  = 4'd1,
    parameter logic [3:0] ADDR_MIN1   = 4'd2,
    parameter logic [3:0] ADDR_MIN10  = 4'd3,
    parameter logic [3:0] ADDR_HOUR1  = 4'd4,
    parameter logic [3:0] ADDR_HOUR10 = 4'd5,
    parameter logic [3:0] ADDR_WDAY   = 4'd6,
    parameter logic [3:0] ADDR_DAY1   = 4'd7,
    parameter logic [3:0] ADDR_DAY10  = 4'd8,
    parameter logic [3:0] ADDR_MON1   = 4'd9,
    parameter logic [3:0] ADDR_MON10  = 4'd10,
    parameter logic [3:0] ADDR_YEAR1  = 4'd11,
    parameter logic [3:0] ADDR_YEAR10 = 4'd12
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            write_i,
    input  logic [NIBW-1:0] ctrl_val_i,
    input  logic [BINW-1:0] sec_i,
    input  logic [BINW-1:0] min_i,
    input  logic [BINW-1:0] hour_i,
    input  logic [BINW-1:0] day_i,
    input  logic [BINW-1:0] mon_i,
    input  logic [BINW-1:0] year_i,
    input  logic [NIBW-1:0] wday_i,
    output logic [BINW-1:0] sec_o,
    output logic [BINW-1:0] min_o,
    output logic [BINW-1:0] hour_o,
    output logic [BINW-1:0] day_o,
    output logic [BINW-1:0] mon_o,
    output logic [BINW-1:0] year_o,
    output logic [NIBW-1:0] wday_o,
    output logic            done_o,
    output logic            err_o,
    output logic            ce_o,
    output logic            reg_req_o,
    output logic            reg_wr_o,
    output logic [NIBW-1:0] reg_addr_o,
    output logic [NIBW-1:0] reg_wdata_o,
    input  logic            reg_ack_i,
    input  logic [NIBW-1:0] reg_rdata_i
);
    localparam int ATT_W  = $clog2(RETRY_MAX + 1);
    localparam int ITEM_W = $clog2(NITEM);
    localparam int LAST   = NITEM - 1;

    // item k: fields in order, ones digit first, weekday last
    localparam logic [NITEM-1:0][NIBW-1:0] ITEM_ADDR = {
        ADDR_WDAY,  ADDR_YEAR10, ADDR_YEAR1, ADDR_MON10,  ADDR_MON1,
        ADDR_DAY10, ADDR_DAY1,   ADDR_HOUR10, ADDR_HOUR1, ADDR_MIN10,
        ADDR_MIN1,  ADDR_SEC10,  ADDR_SEC1
    };

    typedef struct packed {
        seq_state_e                     st;
        logic                           wr;
        logic [ATT_W-1:0]               att;
        logic [ITEM_W-1:0]              item;
        logic                           fail;
        logic [NFIELD-1:0][7:0]         wbcd;
        logic [NIBW-1:0]                wwday;
        logic [2*NFIELD-1:0][NIBW-1:0]  shadow;
        logic [NFIELD-1:0][BINW-1:0]    tout;
        logic [NIBW-1:0]                wday;
    } seq_t;

    seq_t d, q;

    logic [NFIELD-1:0][BINW-1:0] bin_in;
    logic [NFIELD-1:0][7:0]      bcd_in;
    logic [NFIELD-1:0][BINW-1:0] bin_rd;
    logic                        tmr_load;
    logic                        tmr_exp;
    logic                        req_c;
    logic                        wr_c;
    logic [NIBW-1:0]             addr_c;
    logic [NIBW-1:0]             wdata_c;

    assign bin_in = {year_i, mon_i, day_i, hour_i, min_i, sec_i};

    genvar f;
    generate
        for (f = 0; f < NFIELD; f++) begin : g_field
            rtc_bin2bcd #(.WRAP(f == NFIELD - 1)) u_b2b (
                .bin_i (bin_in[f]),
                .bcd_o (bcd_in[f])
            );
            rtc_bcd2bin u_b2n (
                .ones_i (q.shadow[2*f]),
                .tens_i (q.shadow[2*f+1]),
                .bin_o  (bin_rd[f])
            );
        end
    endgenerate

    rtc_wait_timer #(.CYCLES(WAIT_CYC)) u_tmr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .expired_o (tmr_exp)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        req_c    = 1'b0;
        wr_c     = 1'b0;
        addr_c   = ADDR_CTRL;
        wdata_c  = ctrl_val_i;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.st    = S_CTL_WR;
                    d.wr    = write_i;
                    d.att   = '0;
                    d.fail  = 1'b0;
                    d.wbcd  = bcd_in;
                    d.wwday = wday_i;
                end
            end
            S_CTL_WR: begin
                req_c = 1'b1;
                wr_c  = 1'b1;
                if (reg_ack_i) d.st = S_CTL_RD;
            end
            S_CTL_RD: begin
                req_c = 1'b1;
                if (reg_ack_i) begin
                    if (reg_rdata_i[BUSY_BIT]) begin
                        if (q.att == ATT_W'(RETRY_MAX - 1)) begin
                            d.st   = S_FIN;
                            d.fail = 1'b1;
                        end else begin
                            d.att    = q.att + 1'b1;
                            d.st     = S_WAIT;
                            tmr_load = 1'b1;
                        end
                    end else begin
                        d.st   = S_XFER;
                        d.item = '0;
                    end
                end
            end
            S_WAIT: begin
                if (tmr_exp) d.st = S_CTL_WR;
            end
            S_XFER: begin
                req_c  = 1'b1;
                wr_c   = q.wr;
                addr_c = ITEM_ADDR[q.item];
                if (q.item == ITEM_W'(LAST)) begin
                    wdata_c = q.wwday;
                end else if (q.item[0]) begin
                    wdata_c = q.wbcd[q.item[ITEM_W-1:1]][7:4];
                end else begin
                    wdata_c = q.wbcd[q.item[ITEM_W-1:1]][3:0];
                end
                if (reg_ack_i) begin
                    if (q.item == ITEM_W'(LAST)) begin
                        d.st = S_FIN;
                        if (!q.wr) begin
                            d.tout = bin_rd;
                            d.wday = reg_rdata_i;
                        end
                    end else begin
                        if (!q.wr) d.shadow[q.item] = reg_rdata_i;
                        d.item = q.item + 1'b1;
                    end
                end
            end
            S_FIN: begin
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign ce_o        = (q.st == S_CTL_WR) || (q.st == S_CTL_RD) || (q.st == S_XFER);
    assign done_o      = (q.st == S_FIN) && !q.fail;
    assign err_o       = (q.st == S_FIN) && q.fail;
    assign reg_req_o   = req_c;
    assign reg_wr_o    = wr_c;
    assign reg_addr_o  = addr_c;
    assign reg_wdata_o = wdata_c;
    assign sec_o       = q.tout[0];
    assign min_o       = q.tout[1];
    assign hour_o      = q.tout[2];
    assign day_o       = q.tout[3];
    assign mon_o       = q.tout[4];
    assign year_o      = q.tout[5];
    assign wday_o      = q.wday;
endmodule

// File: rtl/rtc_time_seq_chk.sv
module rtc_time_seq_chk #(
    parameter int WAIT_CYC = 8
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       ce_o,
    input logic       reg_req_o,
    input logic       reg_ack_i,
    input logic       reg_wr_o,
    input logic [3:0] reg_addr_o,
    input logic [3:0] reg_wdata_o,
    input logic       done_o,
    input logic       err_o,
    input logic [6:0] sec_o,
    input logic [3:0] wday_o
);
    logic        ce_prev_q;
    logic        mid_q;
    logic [15:0] low_run_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ce_prev_q <= 1'b0;
            mid_q     <= 1'b0;
            low_run_q <= '0;
        end else begin
            ce_prev_q <= ce_o;
            if (ce_o) low_run_q <= '0;
            else if (low_run_q != 16'hFFFF) low_run_q <= low_run_q + 1'b1;
            if (ce_prev_q && !ce_o && !done_o && !err_o) mid_q <= 1'b1;
            else if (ce_o) mid_q <= 1'b0;
        end
    end

    // R11: accesses happen only inside a chip-enable window
    p_req_in_ce_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_req_o |-> ce_o);

    // R11: a pending request holds its address, direction and data
    p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_addr_o)
                                       && $stable(reg_wr_o) && $stable(reg_wdata_o)));

    // R10: success and failure never coincide
    p_done_err_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && err_o));

    // R9: done is a single-cycle pulse with chip-enable released
    p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!ce_o ##1 !done_o));

    // R4: error is a single-cycle pulse with chip-enable released
    p_err_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (!ce_o ##1 !err_o));

    // R6: read results only move together with done
    p_out_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(sec_o) || !$stable(wday_o)) |-> done_o);

    // R3: a retry gap lasts at least WAIT_CYC low cycles
    p_retry_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_o && !ce_prev_q && mid_q) |-> (low_run_q >= 16'(WAIT_CYC)));
endmodule

bind rtc_time_seq rtc_time_seq_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_o        (ce_o),
    .reg_req_o   (reg_req_o),
    .reg_ack_i   (reg_ack_i),
    .reg_wr_o    (reg_wr_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .sec_o       (sec_o),
    .wday_o      (wday_o)
);

// File: tb/rtc_time_seq_bench.sv
`timescale 1ns/1ps
module rtc_time_seq_bench;
    localparam int WAIT_CYC = 4;
    localparam int BUSY_BIT = 1;
    localparam logic [3:0] CTRL_ADDR = 4'd15;
    localparam logic [3:0] CTRL_VAL  = 4'b1001;
    localparam logic [3:0] ORDER [13] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5,
                                          4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd6};

    typedef struct packed {
        logic       wr;
        logic [6:0] sec, mn, hr, dy, mo, yr;
        logic [3:0] wd;
        logic [3:0] busy;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 7'd45, 7'd59, 7'd23, 7'd31, 7'd12, 7'd99,  4'd6, 4'd0},
        '{1'b0, 7'd7,  7'd30, 7'd9,  7'd1,  7'd1,  7'd0,   4'd0, 4'd2},
        '{1'b1, 7'd0,  7'd0,  7'd0,  7'd1,  7'd1,  7'd123, 4'd3, 4'd9},
        '{1'b0, 7'd59, 7'd0,  7'd12, 7'd28, 7'd2,  7'd50,  4'd5, 4'd1},
        '{1'b1, 7'd10, 7'd20, 7'd19, 7'd15, 7'd7,  7'd100, 4'd2, 4'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, wr_cmd = 1'b0;
    logic [6:0] sec_i = '0, min_i = '0, hour_i = '0, day_i = '0, mon_i = '0, year_i = '0;
    logic [3:0] wday_i = '0;
    logic [6:0] sec_o, min_o, hour_o, day_o, mon_o, year_o;
    logic [3:0] wday_o;
    logic done, err, ce, req, rwr, ack = 1'b0;
    logic [3:0] addr, wdata, rdata = '0;

    always #4 clk = ~clk;

    rtc_time_seq #(.WAIT_CYC(WAIT_CYC), .BUSY_BIT(BUSY_BIT)) u_rtc_time_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr_cmd),
        .ctrl_val_i(CTRL_VAL), .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i),
        .day_i(day_i), .mon_i(mon_i), .year_i(year_i), .wday_i(wday_i),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o),
        .mon_o(mon_o), .year_o(year_o), .wday_o(wday_o), .done_o(done), .err_o(err),
        .ce_o(ce), .reg_req_o(req), .reg_wr_o(rwr), .reg_addr_o(addr),
        .reg_wdata_o(wdata), .reg_ack_i(ack), .reg_rdata_i(rdata));

    int errors = 0, checks = 0;
    logic [3:0] mem [16];
    logic [3:0] log_addr [13];
    int busy_left = 0, lat = 0;
    int n_fld = 0, n_crd = 0, n_cwr = 0, n_cbad = 0, n_noce = 0, ce_falls = 0;
    int n_done = 0, n_err = 0;
    logic ce_prev = 1'b0;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // register master and chip model, driven away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (ce_prev && !ce) ce_falls++;
            ce_prev = ce;
            if (done) n_done++;
            if (err) n_err++;
            if (ack) begin
                ack = 1'b0;
            end else if (rst_n && req) begin
                if (lat == 0) begin
                    lat = 1;
                end else begin
                    lat = 0;
                    ack = 1'b1;
                    if (!ce) n_noce++;
                    if (addr == CTRL_ADDR) begin
                        if (rwr) begin
                            n_cwr++;
                            if (wdata != CTRL_VAL) n_cbad++;
                        end else begin
                            n_crd++;
                            rdata = (busy_left > 0) ? (CTRL_VAL | 4'b0010) : (CTRL_VAL & 4'b1101);
                            if (busy_left > 0) busy_left--;
                        end
                    end else begin
                        if (n_fld < 13) log_addr[n_fld] = addr;
                        n_fld++;
                        if (rwr) mem[addr] = wdata;
                        else rdata = mem[addr];
                    end
                end
            end
        end
    end

    task automatic clear_stats();
        n_fld = 0; n_crd = 0; n_cwr = 0; n_cbad = 0; n_noce = 0; ce_falls = 0;
        n_done = 0; n_err = 0;
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk); #1;
        busy_left = int'(v.busy);
        wr_cmd = v.wr; sec_i = v.sec; min_i = v.mn; hour_i = v.hr;
        day_i = v.dy; mon_i = v.mo; year_i = v.yr; wday_i = v.wd;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    logic got_done, got_err;
    task automatic wait_end();
        got_done = 1'b0; got_err = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk); #1;
            if (done || err) begin
                got_done = done; got_err = err;
                return;
            end
        end
        check(1'b0, "watchdog command", 0, 1);
    endtask

    task automatic preload(input vec_t v);
        logic [6:0] fv [6];
        fv = '{v.sec, v.mn, v.hr, v.dy, v.mo, v.yr};
        for (int f = 0; f < 6; f++) begin
            mem[ORDER[2*f]]   = 4'(fv[f] % 10);
            mem[ORDER[2*f+1]] = 4'(fv[f] / 10);
        end
        mem[6] = v.wd;
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "global watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(!ce && !req && !done && !err, "R1 reset controls", {ce, req, done, err}, 0);
        check(sec_o == 0 && year_o == 0 && wday_o == 0, "R1 reset outputs", sec_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!ce && !req && !done && !err, "R1 idle after reset", {ce, req, done, err}, 0);

        for (int k = 0; k < NVEC; k++) begin
            vec_t v;
            v = VEC[k];
            if (!v.wr) preload(v);
            clear_stats();
            launch(v);
            wait_end();
            check(got_done && !got_err, "R9 done on success", {got_done, got_err}, 2);
            check(!ce, "R9 ce low at done", ce, 0);
            check(n_crd == int'(v.busy) + 1, "R2 control reads", n_crd, int'(v.busy) + 1);
            check(n_cwr == int'(v.busy) + 1 && n_cbad == 0, "R2 control writes", n_cwr, int'(v.busy) + 1);
            check(ce_falls == int'(v.busy) + 1, "R3 ce drops per retry", ce_falls, int'(v.busy) + 1);
            check(n_noce == 0, "R11 access with ce low", n_noce, 0);
            check(n_fld == 13, "R5 field access count", n_fld, 13);
            for (int j = 0; j < 13; j++)
                check(log_addr[j] == ORDER[j], "R5 field order", log_addr[j], ORDER[j]);
            if (v.wr) begin
                logic [6:0] fv [6];
                fv = '{v.sec, v.mn, v.hr, v.dy, v.mo, v.yr % 7'd100};
                for (int f = 0; f < 6; f++) begin
                    check(mem[ORDER[2*f]] == 4'(fv[f] % 10), (f == 5) ? "R8 year ones" : "R7 ones digit",
                          mem[ORDER[2*f]], fv[f] % 10);
                    check(mem[ORDER[2*f+1]] == 4'(fv[f] / 10), (f == 5) ? "R8 year tens" : "R7 tens digit",
                          mem[ORDER[2*f+1]], fv[f] / 10);
                end
                check(mem[6] == v.wd, "R7 weekday nibble", mem[6], v.wd);
            end else begin
                check(sec_o == v.sec && min_o == v.mn && hour_o == v.hr, "R6 sec/min/hour",
                      {sec_o, min_o, hour_o}, {v.sec, v.mn, v.hr});
                check(day_o == v.dy && mon_o == v.mo && year_o == v.yr, "R6 day/mon/year",
                      {day_o, mon_o, year_o}, {v.dy, v.mo, v.yr});
                check(wday_o == v.wd, "R6 weekday", wday_o, v.wd);
            end
            repeat (2) @(negedge clk);
        end

        // R4 / R10: all ten attempts busy, outputs keep the last read (vector 3)
        begin
            vec_t e;
            e = '{1'b0, 7'd1, 7'd2, 7'd3, 7'd4, 7'd5, 7'd6, 4'd1, 4'd10};
            clear_stats();
            launch(e);
            wait_end();
            check(got_err && !got_done, "R4 error pulse", {got_done, got_err}, 1);
            check(!ce, "R4 ce low at error", ce, 0);
            check(n_fld == 0, "R4 no field access", n_fld, 0);
            check(n_crd == 10, "R4 attempts", n_crd, 10);
            check(ce_falls == 10, "R3 ce drops on failure", ce_falls, 10);
            @(negedge clk); #1;
            check(!err && !done, "R4 error one cycle", err, 0);
            check(sec_o == VEC[3].sec && year_o == VEC[3].yr && wday_o == VEC[3].wd,
                  "R10 outputs unchanged", sec_o, VEC[3].sec);
        end

        // R12: a second start mid-command is ignored
        begin
            vec_t a, b;
            a = '{1'b1, 7'd33, 7'd44, 7'd5, 7'd6, 7'd8, 7'd21, 4'd4, 4'd0};
            b = '{1'b0, 7'd11, 7'd11, 7'd11, 7'd11, 7'd11, 7'd11, 4'd7, 4'd0};
            clear_stats();
            launch(a);
            repeat (10) @(negedge clk);
            launch(b);
            wait_end();
            repeat (40) @(negedge clk);
            #1;
            check(n_done == 1 && n_err == 0, "R12 single completion", n_done, 1);
            check(n_fld == 13 && n_crd == 1, "R12 single session", n_fld, 13);
            check(mem[ORDER[0]] == 4'd3 && mem[ORDER[1]] == 4'd3 && mem[6] == 4'd4,
                  "R12 original data written", mem[ORDER[1]], 3);
            check(!ce && !req, "R12 idle afterwards", {ce, req}, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule